// File: doc/BRIEF.md
# Transpose Buffer with Last-Element Forwarding

This block sits between the row pass and the column pass of a two-dimensional transform that can run at 4, 8, 16 or 32 points. During the row phase it takes one transformed row per cycle, up to 32 signed samples wide. Each row is first held in a staging register and then written into a square register array. The array is sized for the largest transform. For an N-point transform only the top-left NxN corner is used.

The block switches to the column phase on the cycle after the last row of a frame is accepted. It then sends out one column per cycle for N cycles, and these columns are fed back into the transform input. On that first column cycle the final row is still in the staging register, so the array does not yet hold the bottom element of column 0. A forwarding multiplexer takes that one element from element 0 of the staged row instead. The multiplexer is selected for exactly one cycle. After the last column, a one-cycle done pulse marks the end of the frame.

The column-valid output is also the phase flag that steers the transform's input multiplexer between external rows and fed-back columns.

Top module: `tpose_buffer`

## Requirements
- R1: After a synchronous active-high reset, col_valid and done are low and col_data is all zero.
- R2: In the row phase, each cycle with row_valid high accepts row_data as the next row of the frame, starting at row 0. The frame ends after N accepted rows.
- R3: On the first column cycle, lane N-1 of col_data equals sample 0 of the last accepted row, even though that row has not yet reached the array.
- R4: col_valid rises on the cycle right after the last row is accepted and stays high for exactly N cycles. On column cycle j, lane i (i < N) carries sample j of row i, where lane k occupies bits [k*W +: W].
- R5: done is high for exactly one cycle, the cycle after the last column, and col_valid is low in that cycle.
- R6: row_valid and row_data are ignored while col_valid is high. They change neither the stored rows nor the row count.
- R7: Lanes at or above N are zero while columns are streamed, and all of col_data is zero whenever col_valid is low.
- R8: size_sel codes 0, 1, 2 and 3 select N = 4, 8, 16 and 32, with N limited to the array dimension. The code is sampled with row 0, and later changes within the frame have no effect.
- R9: Cycles with row_valid low during the row phase pause the frame without losing the row position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_sel | input | 2 | Transform size code (0:4, 1:8, 2:16, 3:32 points) |
| row_valid | input | 1 | Row strobe for the row phase |
| row_data | input | MAXN*W | One transformed row, lane k = sample k |
| col_valid | output | 1 | Column phase flag; a column is present on col_data |
| col_data | output | MAXN*W | One column, lane i = sample from row i |
| done | output | 1 | One-cycle pulse after the last column of a frame |

## Verification
The bench builds the buffer with a 16x16 array and 12-bit samples. At this size every legal code can be swept in one short run, with every lane of every column compared, and code 3 exercises the limit on N. The bench changes the frame data from frame to frame. A missing forward would therefore show a stale sample in lane N-1 of column 0. The bench also adds idle gaps, mid-frame size changes and junk rows during the column phase, which reach the pause, size-hold and ignore paths.

// File: rtl/tpose_pkg.sv
package tpose_pkg;

    localparam int TP_LIMIT = 32;
    localparam int TP_IDX_W = 5;

    typedef enum logic [1:0] {
        SZ_4  = 2'd0,
        SZ_8  = 2'd1,
        SZ_16 = 2'd2,
        SZ_32 = 2'd3
    } size_code_e;

    typedef enum logic {
        PH_ROW = 1'b0,
        PH_COL = 1'b1
    } phase_e;

    typedef logic [TP_IDX_W-1:0] idx_t;
    typedef logic [TP_IDX_W:0]   cnt_t;

    // write control carried alongside a row through the staging register
    typedef struct packed {
        logic en;
        idx_t row;
        cnt_t npts;
    } wr_ctl_t;

    function automatic cnt_t size_points(input logic [1:0] code, input int maxn);
        int n;
        n = 4 << code;
        if (n > maxn) n = maxn;
        return cnt_t'(n);
    endfunction

endpackage

// File: rtl/tpose_ctrl.sv
module tpose_ctrl
    import tpose_pkg::*;
#(
    parameter int MAXN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        row_valid,
    input  logic [1:0]  size_sel,
    output wr_ctl_t     wr,
    output phase_e      phase,
    output idx_t        col_idx,
    output cnt_t        npts,
    output logic        fwd_sel,
    output logic        done
);

    phase_e phase_q;
    idx_t   row_cnt;
    idx_t   col_cnt;
    cnt_t   n_q;
    logic   done_q;

    cnt_t   n_eff;
    logic   accept;
    logic   last_row;
    logic   last_col;

    always_comb begin
        n_eff    = (phase_q == PH_ROW && row_cnt == '0) ? size_points(size_sel, MAXN) : n_q;
        accept   = row_valid && (phase_q == PH_ROW);
        last_row = accept && ({1'b0, row_cnt} == n_eff - cnt_t'(1));
        last_col = (phase_q == PH_COL) && ({1'b0, col_cnt} == n_q - cnt_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ROW;
            row_cnt <= '0;
            col_cnt <= '0;
            n_q     <= size_points(2'd0, MAXN);
            done_q  <= 1'b0;
        end else begin
            done_q <= last_col;
            if (accept) begin
                if (row_cnt == '0) n_q <= n_eff;
                if (last_row) begin
                    row_cnt <= '0;
                    col_cnt <= '0;
                    phase_q <= PH_COL;
                end else begin
                    row_cnt <= row_cnt + idx_t'(1);
                end
            end
            if (last_col) begin
                phase_q <= PH_ROW;
                col_cnt <= '0;
            end else if (phase_q == PH_COL) begin
                col_cnt <= col_cnt + idx_t'(1);
            end
        end
    end

    always_comb begin
        wr.en   = accept;
        wr.row  = row_cnt;
        wr.npts = n_eff;
        phase   = phase_q;
        col_idx = col_cnt;
        npts    = n_q;
        fwd_sel = (phase_q == PH_COL) && (col_cnt == '0);
        done    = done_q;
    end

    // R2: a partly received frame never counts past its size
    a_r2_row_in_range: assert property (@(posedge clk) disable iff (rst)
        (row_cnt != '0) |-> ({1'b0, row_cnt} < n_q));

    // R4: columns begin right after the last row
    a_r4_col_start: assert property (@(posedge clk) disable iff (rst)
        last_row |=> (phase_q == PH_COL && col_cnt == '0));

    // R3: forwarding select lasts a single cycle
    a_r3_fwd_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fwd_sel |=> !fwd_sel);

    // R5: done is a one-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R8: the size chosen with row 0 holds for the rest of the frame
    a_r8_size_hold: assert property (@(posedge clk) disable iff (rst)
        (accept && row_cnt != '0) |=> $stable(n_q));

endmodule

// File: rtl/tpose_stage.sv
module tpose_stage
    import tpose_pkg::*;
#(
    parameter int W    = 16,
    parameter int MAXN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_ctl_t             wr_in,
    input  logic [MAXN*W-1:0]   row_in,
    output wr_ctl_t             wr_q,
    output logic [MAXN*W-1:0]   row_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            row_q <= '0;
        end else begin
            wr_q <= wr_in;
            if (wr_in.en) row_q <= row_in;
        end
    end

endmodule

// File: rtl/tpose_array.sv
module tpose_array
    import tpose_pkg::*;
#(
    parameter int W    = 16,
    parameter int MAXN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_ctl_t             wr,
    input  logic [MAXN*W-1:0]   row,
    input  logic                col_en,
    input  idx_t                col_idx,
    input  cnt_t                npts,
    input  logic                fwd_sel,
    output logic [MAXN*W-1:0]   col_out
);

    localparam int IDXW = (MAXN > 1) ? $clog2(MAXN) : 1;

    logic [W-1:0] mem [MAXN][MAXN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < MAXN; r++)
                for (int c = 0; c < MAXN; c++)
                    mem[r][c] <= '0;
        end else if (wr.en) begin
            for (int r = 0; r < MAXN; r++)
                for (int c = 0; c < MAXN; c++)
                    if (wr.row == idx_t'(r) && cnt_t'(c) < wr.npts)
                        mem[r][c] <= row[c*W +: W];
        end
    end

    always_comb begin
        col_out = '0;
        if (col_en) begin
            for (int i = 0; i < MAXN; i++) begin
                if (cnt_t'(i) < npts) begin
                    if (fwd_sel && cnt_t'(i) == npts - cnt_t'(1))
                        col_out[i*W +: W] = row[W-1:0];
                    else
                        col_out[i*W +: W] = mem[i][col_idx[IDXW-1:0]];
                end
            end
        end
    end

    // R3: the staged row is the frame's last row whenever forwarding is selected
    a_r3_fwd_source: assert property (@(posedge clk) disable iff (rst)
        fwd_sel |-> (wr.en && {1'b0, wr.row} == npts - cnt_t'(1)));

endmodule

// File: rtl/tpose_buffer.sv
module tpose_buffer
    import tpose_pkg::*;
#(
    parameter int W    = 16,
    parameter int MAXN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          size_sel,
    input  logic                row_valid,
    input  logic [MAXN*W-1:0]   row_data,
    output logic                col_valid,
    output logic [MAXN*W-1:0]   col_data,
    output logic                done
);

    wr_ctl_t            wr_c;
    wr_ctl_t            wr_s;
    logic [MAXN*W-1:0]  row_s;
    phase_e             phase;
    idx_t               col_idx;
    cnt_t               npts;
    logic               fwd_sel;

    tpose_ctrl #(.MAXN(MAXN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .row_valid (row_valid),
        .size_sel  (size_sel),
        .wr        (wr_c),
        .phase     (phase),
        .col_idx   (col_idx),
        .npts      (npts),
        .fwd_sel   (fwd_sel),
        .done      (done)
    );

    tpose_stage #(.W(W), .MAXN(MAXN)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .wr_in  (wr_c),
        .row_in (row_data),
        .wr_q   (wr_s),
        .row_q  (row_s)
    );

    tpose_array #(.W(W), .MAXN(MAXN)) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_s),
        .row     (row_s),
        .col_en  (phase == PH_COL),
        .col_idx (col_idx),
        .npts    (npts),
        .fwd_sel (fwd_sel),
        .col_out (col_data)
    );

    assign col_valid = (phase == PH_COL);

    // R6: nothing enters staging from a column-phase cycle
    a_r6_no_rows_in_cols: assert property (@(posedge clk) disable iff (rst)
        wr_s.en |-> ($past(phase) == PH_ROW));

    // R5: done never overlaps a column
    a_r5_done_no_col: assert property (@(posedge clk) disable iff (rst)
        done |-> !col_valid);

    // R7: the column bus is quiet outside the column phase
    a_r7_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !col_valid |-> (col_data == '0));

endmodule

// File: tb/test_tpose_buffer.sv
module test_tpose_buffer;

    localparam int W    = 12;
    localparam int MAXN = 16;
    localparam int BW   = MAXN * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    size_sel = 2'd0;
    logic          row_valid = 1'b0;
    logic [BW-1:0] row_data = '0;
    logic          col_valid;
    logic [BW-1:0] col_data;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tpose_buffer #(.W(W), .MAXN(MAXN)) i_tpose_buffer (
        .clk       (clk),
        .rst       (rst),
        .size_sel  (size_sel),
        .row_valid (row_valid),
        .row_data  (row_data),
        .col_valid (col_valid),
        .col_data  (col_data),
        .done      (done)
    );

    function automatic logic [W-1:0] sample(int fr, int r, int c);
        return W'(fr * 37 + r * 11 + c * 5 + 3);
    endfunction

    function automatic logic [BW-1:0] make_row(int fr, int r);
        logic [BW-1:0] v;
        for (int c = 0; c < MAXN; c++) v[c*W +: W] = sample(fr, r, c);
        return v;
    endfunction

    function automatic logic [BW-1:0] make_col(int fr, int j, int n);
        logic [BW-1:0] v;
        v = '0;
        for (int i = 0; i < n; i++) v[i*W +: W] = sample(fr, i, j);
        return v;
    endfunction

    task automatic chk_bus(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    // one frame: rows, then columns, then the done cycle
    task automatic run_frame(int code, int fr, bit gaps, bit junk, bit chg);
        int n;
        n = 4 << code;
        if (n > MAXN) n = MAXN;
        for (int r = 0; r < n; r++) begin
            @(negedge clk);
            if (gaps && (r == 1 || r == n - 1)) begin
                row_valid = 1'b0;
                row_data  = '1;
                @(negedge clk);
                chk_bit("R9 idle gap keeps row phase", col_valid, 1'b0);
            end
            size_sel  = (chg && r > 0) ? 2'(code ^ 1) : 2'(code);
            row_valid = 1'b1;
            row_data  = make_row(fr, r);
        end
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk_bit("R4 col_valid during columns", col_valid, 1'b1);
            chk_bit("R5 no done during columns", done, 1'b0);
            if (j == 0)
                chk_bus("R3 forwarded first column", col_data, make_col(fr, 0, n));
            else
                chk_bus("R4 R7 column contents", col_data, make_col(fr, j, n));
            row_valid = junk;
            row_data  = {BW{1'b1}} ^ make_row(fr + 99, j);
        end
        @(negedge clk);
        chk_bit("R5 done pulse", done, 1'b1);
        chk_bit("R5 col_valid low with done", col_valid, 1'b0);
        chk_bus("R7 bus quiet after columns", col_data, '0);
        row_valid = 1'b0;
        @(negedge clk);
        chk_bit("R5 done single cycle", done, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_bit("R1 col_valid reset", col_valid, 1'b0);
        chk_bit("R1 done reset", done, 1'b0);
        chk_bus("R1 col_data reset", col_data, '0);
        rst = 1'b0;
        run_frame(0, 1, 0, 0, 0);   // R2 N=4 plain
        run_frame(1, 2, 1, 1, 0);   // R9 R6 N=8 gaps, junk in columns
        run_frame(2, 3, 0, 1, 1);   // R8 N=16, size changes mid-frame
        run_frame(3, 4, 1, 0, 0);   // R8 code 3 limited to 16
        run_frame(0, 5, 0, 1, 1);   // R8 R6 N=4 after a larger frame
        run_frame(1, 6, 0, 0, 0);   // R2 N=8 plain
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule